// File: doc/BRIEF.md
# Two-level maskable interrupt controller

This block gathers interrupt events from a small processor's surroundings into sticky flag bits and decides when the core must be interrupted. Three core sources (external pin edge, port change, timer-0 overflow) are masked only by their own enable and the global enable. Up to sixteen peripheral sources are masked by their own enable, then by a peripheral-group enable, then by the global enable. Flags latch on every event whatever the enables say. Software clears them only by writing the register that holds them.

When the gated request is high and the core strobes its accept input, the block clears the global enable. On the next cycle it pulses a return-address push request and a program-counter load carrying the fixed vector 0x0004. A return-from-interrupt input sets the global enable again. Any flag still set then raises the request once more. A wake-up output tells a sleeping core that some enabled source is pending, whatever the state of the global enable.

Software reaches the flags and enables through a byte-wide register port with combinational read data and writes that take effect at the clock edge.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all flags, individual enables, the group enable and the global enable are 0, and irq_o, wake_o, push_o and pc_load_o are low.
- R2: Register layout. Address 0 holds the core flags in bits 0 (pin edge), 1 (port change) and 2 (timer overflow), their enables in bits 3 to 5 in the same order, the group enable in bit 6 and the global enable in bit 7. Addresses 1 and 2 hold peripheral flags 0–7 and 8 onward, and addresses 3 and 4 hold the matching enables, each LSB-aligned. Bits with no source and addresses 5 to 7 read 0, and writes to them have no effect.
- R3: An event pulse sets its flag at that clock edge, whatever its own enable, the group enable and the global enable hold.
- R4: A register write stores the written value into the flags, but a hardware event on the same flag in the same cycle leaves it set. Accepting an interrupt never clears a flag.
- R5: irq_o is high exactly when the global enable is set and some core flag has its enable set, or the group enable is set and some peripheral flag has its enable set. It rises in the cycle after the event edge.
- R6: An accept (ack_i high while irq_o is high) clears the global enable at that edge, even when a register write sets it in the same cycle.
- R7: In the cycle after an accept, push_o and pc_load_o are high for one cycle with vector_o = 0x0004. vector_o is 0 in every other cycle.
- R8: retfie_i sets the global enable at the next edge, overriding a same-cycle register write. A pending enabled flag then raises irq_o again.
- R9: wake_o follows the same gating as irq_o without the global enable.
- R10: ack_i while irq_o is low is ignored: the global enable keeps its value and no push follows.
- R11: A register write to the global enable is visible on irq_o and on read-back from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_evt_i | input | 3 | Core source event pulses (pin edge, port change, timer) |
| periph_evt_i | input | NUM_PERIPH | Peripheral event pulses |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| ack_i | input | 1 | Core accept strobe |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| push_o | output | 1 | Return-address push request |
| pc_load_o | output | 1 | Program-counter load strobe |
| vector_o | output | PC_W | Vector address while pc_load_o is high |
| wake_o | output | 1 | Wake-up request |

## Verification
Flags, enables and the global enable change at the edge where their event, write, accept or return strobe is sampled. Read data, irq_o and wake_o are combinational from that state, so they show the change one cycle later. push_o, pc_load_o and vector_o are registered and appear in the cycle after the accepting edge. The bench drives inputs just after the falling edge and checks read data, irq_o and wake_o against a model of the pre-edge state. It advances the model at the rising edge and checks the registered push outputs at the following falling edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NUM_CORE   = 3;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned CORE_EN_LSB = 3;
  localparam int unsigned GROUP_BIT  = 6;
  localparam int unsigned GIE_BIT    = 7;

  typedef enum logic [2:0] {
    ADDR_MAIN     = 3'd0,
    ADDR_PFLAG_LO = 3'd1,
    ADDR_PFLAG_HI = 3'd2,
    ADDR_PEN_LO   = 3'd3,
    ADDR_PEN_HI   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] flag_we_i,
  input  logic [W-1:0] flag_wdata_i,
  input  logic [W-1:0] en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic flag_q, en_q;
    // hardware event dominates a same-cycle software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        flag_q <= evt_i[i] | (flag_we_i[i] ? flag_wdata_i[i] : flag_q);
        if (en_we_i[i]) en_q <= en_wdata_i[i];
      end
    end
    assign flag_o[i] = flag_q;
    assign en_o[i]   = en_q;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NUM_CORE   = 3,
  parameter int unsigned NUM_PERIPH = 11
) (
  input  logic [NUM_CORE-1:0]   core_flag_i,
  input  logic [NUM_CORE-1:0]   core_en_i,
  input  logic [NUM_PERIPH-1:0] periph_flag_i,
  input  logic [NUM_PERIPH-1:0] periph_en_i,
  input  logic                  group_en_i,
  output logic                  pend_o
);
  logic core_any, periph_any;
  assign core_any   = |(core_flag_i & core_en_i);
  assign periph_any = |(periph_flag_i & periph_en_i);
  assign pend_o     = core_any | (group_en_i & periph_any);
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl #(
  parameter int unsigned        PC_W   = 13,
  parameter logic [PC_W-1:0]    VECTOR = 'h4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            main_we_i,
  input  logic            gie_wdata_i,
  input  logic            group_wdata_i,
  input  logic            pend_i,
  input  logic            ack_i,
  input  logic            retfie_i,
  output logic            gie_o,
  output logic            group_en_o,
  output logic            irq_o,
  output logic            push_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] vector_o
);
  logic gie_q, group_q, take_q, accept;

  assign irq_o  = gie_q & pend_i;
  assign accept = ack_i & irq_o;

  // priority: accept, then return, then register write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      group_q <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      if (accept)         gie_q <= 1'b0;
      else if (retfie_i)  gie_q <= 1'b1;
      else if (main_we_i) gie_q <= gie_wdata_i;
      if (main_we_i) group_q <= group_wdata_i;
      take_q <= accept;
    end
  end

  assign gie_o      = gie_q;
  assign group_en_o = group_q;
  assign push_o     = take_q;
  assign pc_load_o  = take_q;
  assign vector_o   = take_q ? VECTOR : '0;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned     NUM_PERIPH = 11,
  parameter int unsigned     PC_W       = 13,
  parameter logic [PC_W-1:0] VECTOR     = 'h4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CORE-1:0]   core_evt_i,
  input  logic [NUM_PERIPH-1:0] periph_evt_i,
  input  logic [2:0]            reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  output logic                  irq_o,
  input  logic                  ack_i,
  input  logic                  retfie_i,
  output logic                  push_o,
  output logic                  pc_load_o,
  output logic [PC_W-1:0]       vector_o,
  output logic                  wake_o
);
  localparam int unsigned EXT_W = 2 * LANE_W;

  logic                  main_we;
  logic [NUM_CORE-1:0]   core_flag, core_en;
  logic [NUM_PERIPH-1:0] periph_flag, periph_en;
  logic [NUM_PERIPH-1:0] pf_we, pe_we, p_wdata;
  logic                  group_en, gie_q, pend;

  assign main_we = reg_we_i && (reg_addr_i == ADDR_MAIN);

  irq_flag_bank #(.W(NUM_CORE)) u_core_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (core_evt_i),
    .flag_we_i    ({NUM_CORE{main_we}}),
    .flag_wdata_i (reg_wdata_i[NUM_CORE-1:0]),
    .en_we_i      ({NUM_CORE{main_we}}),
    .en_wdata_i   (reg_wdata_i[CORE_EN_LSB +: NUM_CORE]),
    .flag_o       (core_flag),
    .en_o         (core_en)
  );

  // per-bit lane decode for the peripheral registers
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_plane
    localparam logic [2:0] FA = (i < LANE_W) ? ADDR_PFLAG_LO : ADDR_PFLAG_HI;
    localparam logic [2:0] EA = (i < LANE_W) ? ADDR_PEN_LO   : ADDR_PEN_HI;
    assign pf_we[i]   = reg_we_i && (reg_addr_i == FA);
    assign pe_we[i]   = reg_we_i && (reg_addr_i == EA);
    assign p_wdata[i] = reg_wdata_i[i % LANE_W];
  end

  irq_flag_bank #(.W(NUM_PERIPH)) u_periph_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (periph_evt_i),
    .flag_we_i    (pf_we),
    .flag_wdata_i (p_wdata),
    .en_we_i      (pe_we),
    .en_wdata_i   (p_wdata),
    .flag_o       (periph_flag),
    .en_o         (periph_en)
  );

  irq_gate #(.NUM_CORE(NUM_CORE), .NUM_PERIPH(NUM_PERIPH)) u_gate (
    .core_flag_i   (core_flag),
    .core_en_i     (core_en),
    .periph_flag_i (periph_flag),
    .periph_en_i   (periph_en),
    .group_en_i    (group_en),
    .pend_o        (pend)
  );

  irq_enable_ctl #(.PC_W(PC_W), .VECTOR(VECTOR)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .main_we_i     (main_we),
    .gie_wdata_i   (reg_wdata_i[GIE_BIT]),
    .group_wdata_i (reg_wdata_i[GROUP_BIT]),
    .pend_i        (pend),
    .ack_i         (ack_i),
    .retfie_i      (retfie_i),
    .gie_o         (gie_q),
    .group_en_o    (group_en),
    .irq_o         (irq_o),
    .push_o        (push_o),
    .pc_load_o     (pc_load_o),
    .vector_o      (vector_o)
  );

  assign wake_o = pend;

  logic [EXT_W-1:0] pf_ext, pe_ext;
  always_comb begin
    pf_ext = '0;
    pe_ext = '0;
    pf_ext[NUM_PERIPH-1:0] = periph_flag;
    pe_ext[NUM_PERIPH-1:0] = periph_en;
    unique case (reg_addr_i)
      ADDR_MAIN:     reg_rdata_o = {gie_q, group_en, core_en, core_flag};
      ADDR_PFLAG_LO: reg_rdata_o = pf_ext[7:0];
      ADDR_PFLAG_HI: reg_rdata_o = pf_ext[15:8];
      ADDR_PEN_LO:   reg_rdata_o = pe_ext[7:0];
      ADDR_PEN_HI:   reg_rdata_o = pe_ext[15:8];
      default:       reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned     NUM_PERIPH = 11,
  parameter int unsigned     PC_W       = 13,
  parameter logic [PC_W-1:0] VECTOR     = 'h4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2:0]            core_evt_i,
  input logic [NUM_PERIPH-1:0] periph_evt_i,
  input logic [2:0]            core_flag,
  input logic [NUM_PERIPH-1:0] periph_flag,
  input logic                  gie_q,
  input logic                  main_we,
  input logic                  reg_we_i,
  input logic                  irq_o,
  input logic                  ack_i,
  input logic                  retfie_i,
  input logic                  push_o,
  input logic                  pc_load_o,
  input logic [PC_W-1:0]       vector_o,
  input logic                  wake_o
);
  a_r3_core_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_evt_i != 0) |=> ((core_flag & $past(core_evt_i)) == $past(core_evt_i)));
  a_r3_periph_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_evt_i != 0) |=> ((periph_flag & $past(periph_evt_i)) == $past(periph_evt_i)));
  a_r4_accept_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !reg_we_i) |=> (core_flag == ($past(core_flag) | $past(core_evt_i))));
  a_r5_no_irq_without_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);
  a_r6_accept_clears_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !gie_q);
  a_r7_push_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (push_o && pc_load_o && vector_o == VECTOR));
  a_r7_vector_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_load_o |-> (vector_o == '0));
  a_r8_return_sets_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retfie_i && !(ack_i && irq_o)) |=> gie_q);
  a_r9_irq_implies_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);
  a_r10_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !retfie_i && !main_we) |=> (gie_q == $past(gie_q) && !push_o));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NUM_PERIPH (NUM_PERIPH),
  .PC_W       (PC_W),
  .VECTOR     (VECTOR)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .core_evt_i   (core_evt_i),
  .periph_evt_i (periph_evt_i),
  .core_flag    (core_flag),
  .periph_flag  (periph_flag),
  .gie_q        (gie_q),
  .main_we      (main_we),
  .reg_we_i     (reg_we_i),
  .irq_o        (irq_o),
  .ack_i        (ack_i),
  .retfie_i     (retfie_i),
  .push_o       (push_o),
  .pc_load_o    (pc_load_o),
  .vector_o     (vector_o),
  .wake_o       (wake_o)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  localparam int unsigned NP   = 11;
  localparam int unsigned PC_W = 13;
  localparam logic [PC_W-1:0] VEC = 13'h0004;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      core_evt = '0;
  logic [NP-1:0]   periph_evt = '0;
  logic [2:0]      addr = '0;
  logic            we = 1'b0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic            irq, ack = 1'b0, retfie = 1'b0;
  logic            push, pc_load, wake;
  logic [PC_W-1:0] vector;

  int unsigned n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_ctrl #(.NUM_PERIPH(NP), .PC_W(PC_W), .VECTOR(VEC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .core_evt_i(core_evt), .periph_evt_i(periph_evt),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .ack_i(ack), .retfie_i(retfie), .push_o(push), .pc_load_o(pc_load),
    .vector_o(vector), .wake_o(wake)
  );

  // reference model state
  logic [2:0]  m_cf = '0, m_ce = '0;
  logic        m_grp = 1'b0, m_gie = 1'b0, m_push = 1'b0;
  logic [15:0] m_pf = '0, m_pe = '0;

  function automatic logic f_pend();
    return (|(m_cf & m_ce)) | (m_grp & (|(m_pf & m_pe)));
  endfunction

  function automatic logic f_irq();
    return m_gie & f_pend();
  endfunction

  function automatic logic [7:0] f_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_gie, m_grp, m_ce, m_cf};
      3'd1: return m_pf[7:0];
      3'd2: return m_pf[15:8];
      3'd3: return m_pe[7:0];
      3'd4: return m_pe[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic [2:0] cev, input logic [NP-1:0] pev, input logic [2:0] a,
                       input logic w, input logic [7:0] d, input logic k, input logic r,
                       input string tag);
    logic        acc, gie_n;
    logic [15:0] pf_n, pe_n, pev_x;
    logic [2:0]  cf_n, ce_n;
    logic        grp_n;
    @(negedge clk);
    chk("R7 push", {31'd0, push}, {31'd0, m_push});
    chk("R7 pc_load", {31'd0, pc_load}, {31'd0, m_push});
    chk("R7 vector", 32'(vector), m_push ? 32'(VEC) : 32'd0);
    core_evt = cev; periph_evt = pev; addr = a; we = w; wdata = d; ack = k; retfie = r;
    #1;
    chk(tag, {24'd0, rdata}, {24'd0, f_rd(a)});
    chk("R5 irq", {31'd0, irq}, {31'd0, f_irq()});
    chk("R9 wake", {31'd0, wake}, {31'd0, f_pend()});
    acc   = k & f_irq();
    pev_x = '0; pev_x[NP-1:0] = pev;
    cf_n  = ((w && a == 3'd0) ? d[2:0] : m_cf) | cev;
    ce_n  = (w && a == 3'd0) ? d[5:3] : m_ce;
    grp_n = (w && a == 3'd0) ? d[6] : m_grp;
    gie_n = acc ? 1'b0 : r ? 1'b1 : (w && a == 3'd0) ? d[7] : m_gie;
    pf_n = m_pf; pe_n = m_pe;
    if (w && a == 3'd1) pf_n[7:0]  = d;
    if (w && a == 3'd2) pf_n[15:8] = d;
    if (w && a == 3'd3) pe_n[7:0]  = d;
    if (w && a == 3'd4) pe_n[15:8] = d;
    pf_n = (pf_n | pev_x) & ((16'd1 << NP) - 16'd1);
    pe_n = pe_n & ((16'd1 << NP) - 16'd1);
    @(posedge clk);
    m_cf = cf_n; m_ce = ce_n; m_grp = grp_n; m_gie = gie_n;
    m_pf = pf_n; m_pe = pe_n; m_push = acc;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every register and output
    for (int a = 0; a < 5; a++) cycle('0, '0, 3'(a), 0, 0, 0, 0, "R1 reset");
    // R3: flag sets with all enables off
    cycle(3'b010, '0, 3'd0, 0, 8'h00, 0, 0, "R2");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R3 flag set");
    // R4: write of 0 versus same-cycle event
    cycle(3'b001, '0, 3'd0, 1, 8'h00, 0, 0, "R2");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R4 hw wins");
    // R11: global enable write visible next cycle
    cycle('0, '0, 3'd0, 1, 8'h89, 0, 0, "R2");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R11 gie write");
    // R6: accept beats same-cycle write
    cycle('0, '0, 3'd0, 1, 8'h89, 1, 0, "R2");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R6 accept clears gie");
    // R10: stray ack
    cycle('0, '0, 3'd0, 0, 8'h00, 1, 0, "R10 stray ack");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R10 gie kept");
    // R8: return beats same-cycle write of 0
    cycle('0, '0, 3'd0, 1, 8'h09, 0, 1, "R2");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R8 return sets gie");
    // R9: peripheral pending without group enable, then with it and gie off
    cycle('0, '0, 3'd0, 1, 8'h00, 0, 0, "R2");
    cycle('0, 11'h400, 3'd4, 1, 8'h04, 0, 0, "R2");
    cycle('0, '0, 3'd2, 0, 8'h00, 0, 0, "R3 periph flag");
    cycle('0, '0, 3'd0, 1, 8'h40, 0, 0, "R9 group gate");
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R9 wake no gie");
    // R2: unused address ignores writes
    cycle('0, '0, 3'd5, 1, 8'hFF, 0, 0, "R2");
    cycle('0, '0, 3'd5, 0, 8'h00, 0, 0, "R2 unused addr");
    cycle('0, '0, 3'd2, 1, 8'hFF, 0, 0, "R2");
    cycle('0, '0, 3'd2, 0, 8'h00, 0, 0, "R2 unused bits");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]    cev;
      logic [NP-1:0] pev;
      for (int b = 0; b < 3; b++)  cev[b] = ($urandom % 16) == 0;
      for (int b = 0; b < NP; b++) pev[b] = ($urandom % 24) == 0;
      cycle(cev, pev, 3'($urandom % 6), ($urandom % 5) == 0, 8'($urandom),
            ($urandom % 3) == 0, ($urandom % 8) == 0, "R2 random read");
    end
    cycle('0, '0, 3'd0, 0, 8'h00, 0, 0, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule